// File: doc/BRIEF.md
# Buffered Ping-Pong PWM Channel

This block produces one pulse-width-modulated output from a free-running up-counter and two duty registers, A and B. With the link bit clear it behaves as a plain single-register PWM driven by register A, and a new A value takes effect within the period in progress. With the link bit set, the two registers form a ping-pong buffer. Software writes a new duty into either register. The register written most recently is copied into a staged compare only when the counter wraps, so each duty change starts on a period boundary and the period already running is never disturbed.

The output has an explicit set and an explicit clear. It goes high at the wrap when the coming period's compare value is non-zero, and low when the count reaches the compare value. A zero compare therefore gives a flat low line, and a compare beyond the modulus gives a flat high line. Because the set and clear are recomputed each period, any wrong level is corrected by the next wrap. While the registers are linked, a separate flag tells the surrounding logic that the second channel's pin is free for other use.

Top module: `pingpong_pwm`

## Requirements
- R1: `pinBFree` is high exactly while `linkEn` is high, and the combined waveform appears on `pwmOut`.
- R2: The counter runs 0, 1, ..., `modulus`, then 0 again, so a period lasts `modulus`+1 cycles. During reset the counter is 0 and `pwmOut` is low.
- R3: Once linking is enabled, register A's value sets the duty from the next period on.
- R4: While linked, a write to either register leaves the high time of the current period unchanged.
- R5: While linked, each wrap selects the register written last. If both are written in the same cycle, register B counts as written last.
- R6: A compare value of 0 keeps `pwmOut` low for the whole period.
- R7: A compare value greater than `modulus` keeps `pwmOut` high for the whole period.
- R8: When `linkEn` is cleared, the staged compare stays in force until the next wrap. From that wrap on, register A controls the output directly.
- R9: While unlinked, a write to A takes effect in the current period: if the count has not yet reached the new value, the output falls when it does.
- R10: In each period, `pwmOut` is high for counts below the compare value and low from the compare value on, so the high time equals the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modulus | input | CNT_W | Highest count before wrap |
| wrA | input | 1 | Write strobe for duty register A |
| dataA | input | CNT_W | Duty value for register A |
| wrB | input | 1 | Write strobe for duty register B |
| dataB | input | CNT_W | Duty value for register B |
| linkEn | input | 1 | Joins A and B into a buffered pair |
| pwmOut | output | 1 | PWM waveform |
| pinBFree | output | 1 | Second channel pin released |

## Verification
The bench builds the block with CNT_W = 8 and drives a modulus of 9, which gives a ten-cycle period. That is short enough to place writes at chosen counts inside a period, and it lets a compare value of 15 exceed the modulus to produce full duty. A period's high time can only fall between 0 and 10, so each measured high time shows directly which register, or which staged copy, controlled that period. The tests cover the write ordering within a period, writes in the same cycle, linking and unlinking in mid-period, and the immediate update in unlinked mode.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

  // Which duty register was written most recently.
  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } regSel_t;

  // Strobes passed from the counter datapath to the selection control.
  typedef struct packed {
    logic wrap;      // counter is at modulus; the next edge starts a period
    logic firstCyc;  // counter is at zero
  } cntEvt_t;

endpackage

// File: rtl/ppwm_ctrl.sv
module ppwm_ctrl
  import ppwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntEvt_t          evt,
  input  logic             wrA,
  input  logic [CNT_W-1:0] dataA,
  input  logic             wrB,
  input  logic [CNT_W-1:0] dataB,
  input  logic             linkEn,
  output logic [CNT_W-1:0] cmpCur,
  output logic [CNT_W-1:0] cmpNxt
);

  logic [CNT_W-1:0] regA, regB, regANext, regBNext;
  logic [CNT_W-1:0] activeVal, selNext;
  regSel_t          lastSel, lastNext;
  logic             linkQ, holdQ, linkRise, linkFall, bufMode;

  assign linkRise = linkEn & ~linkQ;
  assign linkFall = ~linkEn & linkQ;
  // The staged copy governs while linked and until the first wrap after unlinking.
  assign bufMode  = linkQ | holdQ;

  always_comb begin
    regANext = wrA ? dataA : regA;
    regBNext = wrB ? dataB : regB;
    if (wrB)                 lastNext = SEL_B;
    else if (wrA || linkRise) lastNext = SEL_A;
    else                     lastNext = lastSel;
    if (linkEn && lastNext == SEL_B) selNext = regBNext;
    else                             selNext = regANext;
  end

  assign cmpCur = bufMode ? activeVal : regA;
  assign cmpNxt = selNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA      <= '0;
      regB      <= '0;
      activeVal <= '0;
      lastSel   <= SEL_A;
      linkQ     <= 1'b0;
      holdQ     <= 1'b0;
    end else begin
      regA    <= regANext;
      regB    <= regBNext;
      lastSel <= lastNext;
      linkQ   <= linkEn;
      if (linkRise || evt.wrap)
        activeVal <= selNext;
      if (linkRise || evt.wrap)
        holdQ <= 1'b0;
      else if (linkFall)
        holdQ <= 1'b1;
    end
  end

  // R4: while linked, the controlling compare is frozen inside a period
  a_r4_frozen_mid_period : assert property (@(posedge clk) disable iff (!rstN)
    (linkEn && linkQ && !evt.wrap) |=> $stable(cmpCur));

  // R5: a write to B in the same cycle as one to A still marks B as last
  a_r5_b_wins : assert property (@(posedge clk) disable iff (!rstN)
    (linkEn && wrB) |=> (lastSel == SEL_B));

  // R5: a B write landing on the wrap cycle controls the new period
  a_r5_wrap_takes_b : assert property (@(posedge clk) disable iff (!rstN)
    (linkEn && linkQ && evt.wrap && wrB) |=> (cmpCur == $past(dataB)));

  // R8: after unlinking, the staged value holds until the wrap
  a_r8_hold_after_unlink : assert property (@(posedge clk) disable iff (!rstN)
    (linkQ && !linkEn && !evt.wrap) |=> $stable(cmpCur));

endmodule

// File: rtl/ppwm_datapath.sv
module ppwm_datapath
  import ppwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] modulus,
  input  logic [CNT_W-1:0] cmpCur,
  input  logic [CNT_W-1:0] cmpNxt,
  output cntEvt_t          evt,
  output logic             pwmOut
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cntInc;
  logic             wrap, matchClr, setLvl;

  assign wrap     = (cnt >= modulus);
  assign cntInc   = {1'b0, cnt} + EXT_W'(1);
  // Clear on the edge where the count reaches the compare value.
  assign matchClr = (cntInc == {1'b0, cmpCur});
  // Set at the wrap unless the coming period has zero duty.
  assign setLvl   = (cmpNxt != '0);

  assign evt.wrap     = wrap;
  assign evt.firstCyc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      pwmOut <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cntInc[CNT_W-1:0];
      if (wrap)
        pwmOut <= setLvl;
      else if (matchClr)
        pwmOut <= 1'b0;
    end
  end

  // R2: counting steps by one below the modulus
  a_r2_count_step : assert property (@(posedge clk) disable iff (!rstN)
    (!wrap && $stable(modulus)) |=> (cnt == $past(cnt) + 1'b1));

  // R2: reaching the modulus returns the count to zero
  a_r2_wrap_zero : assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> evt.firstCyc);

  // R6: zero duty gives a low output from the period start
  a_r6_zero_low : assert property (@(posedge clk) disable iff (!rstN)
    (wrap && cmpNxt == '0) |=> !pwmOut);

  // R10: a non-zero duty raises the output at the period start
  a_r10_set_at_wrap : assert property (@(posedge clk) disable iff (!rstN)
    (wrap && cmpNxt != '0) |=> pwmOut);

  // R7: a compare beyond the modulus never clears the output
  a_r7_full_high : assert property (@(posedge clk) disable iff (!rstN)
    (!wrap && pwmOut && cmpCur > modulus) |=> pwmOut);

endmodule

// File: rtl/pingpong_pwm.sv
module pingpong_pwm
  import ppwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] modulus,
  input  logic             wrA,
  input  logic [CNT_W-1:0] dataA,
  input  logic             wrB,
  input  logic [CNT_W-1:0] dataB,
  input  logic             linkEn,
  output logic             pwmOut,
  output logic             pinBFree
);

  cntEvt_t          evt;
  logic [CNT_W-1:0] cmpCur, cmpNxt;

  ppwm_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (evt),
    .wrA    (wrA),
    .dataA  (dataA),
    .wrB    (wrB),
    .dataB  (dataB),
    .linkEn (linkEn),
    .cmpCur (cmpCur),
    .cmpNxt (cmpNxt)
  );

  ppwm_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .modulus (modulus),
    .cmpCur  (cmpCur),
    .cmpNxt  (cmpNxt),
    .evt     (evt),
    .pwmOut  (pwmOut)
  );

  // While linked, the second channel's pin is handed back for other use.
  assign pinBFree = linkEn;

endmodule

// File: tb/test_pingpong_pwm.sv
`timescale 1ns/1ps
module test_pingpong_pwm;

  localparam int W   = 8;
  localparam int MOD = 9;
  localparam int P   = MOD + 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] modulus = W'(MOD);
  logic         wrA = 1'b0, wrB = 1'b0, linkEn = 1'b0;
  logic [W-1:0] dataA = '0, dataB = '0;
  logic         pwmOut, pinBFree;

  int checks = 0;
  int fails  = 0;
  int bc     = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int hi;

  always #2 clk = ~clk;

  pingpong_pwm #(.CNT_W(W)) i_pingpong_pwm (
    .clk(clk), .rstN(rstN), .modulus(modulus),
    .wrA(wrA), .dataA(dataA), .wrB(wrB), .dataB(dataB),
    .linkEn(linkEn), .pwmOut(pwmOut), .pinBFree(pinBFree)
  );

  // Reference count from R2: 0..MOD, then wrap.
  always @(posedge clk) begin
    if (!rstN) bc <= 0;
    else       bc <= (bc >= MOD) ? 0 : bc + 1;
    cyc <= cyc + 1;
  end

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one full period's high time. Optional writes at count atA/atB
  // and an optional link change at count lkAt happen during that period.
  task automatic runPeriod(output int h, input int atA, input int vA,
                           input int atB, input int vB,
                           input int lkAt, input bit lkVal);
    h = 0;
    @(negedge clk);
    while (bc != 0) @(negedge clk);
    for (int i = 0; i < P; i++) begin
      if (i > 0) @(negedge clk);
      if (pwmOut) h++;
      wrA = 1'b0;
      wrB = 1'b0;
      if (i == atA) begin wrA = 1'b1; dataA = W'(vA); end
      if (i == atB) begin wrB = 1'b1; dataB = W'(vB); end
      if (i == lkAt) linkEn = lkVal;
    end
    wrA = 1'b0;
    wrB = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(int'(pwmOut), 0, "R2 reset output");
    check(int'(pinBFree), 0, "R1 unlinked flag");
  endtask

  task automatic testUnbuffered();
    runPeriod(hi, 8, 4, -1, 0, -1, 1'b0);
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 4, "R10 high time 4");
    runPeriod(hi, 8, 8, -1, 0, -1, 1'b0);
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 8, "R10 high time 8");
    runPeriod(hi, 1, 3, -1, 0, -1, 1'b0);
    check(hi, 3, "R9 immediate unlinked update");
  endtask

  task automatic testLink();
    runPeriod(hi, -1, 0, -1, 0, 5, 1'b1);
    check(int'(pinBFree), 1, "R1 flag while linked");
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 3, "R3 A controls after link");
  endtask

  task automatic testPingPong();
    runPeriod(hi, -1, 0, 1, 7, -1, 1'b0);
    check(hi, 3, "R4 current period unchanged");
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 7, "R4 B active next period");
    runPeriod(hi, 2, 2, 5, 5, -1, 1'b0);
    check(hi, 7, "R4 unchanged after two writes");
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 5, "R5 later write B wins");
    runPeriod(hi, 5, 3, 2, 6, -1, 1'b0);
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 3, "R5 later write A wins");
    runPeriod(hi, 3, 8, 3, 1, -1, 1'b0);
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 1, "R5 same cycle B wins");
  endtask

  task automatic testExtremes();
    runPeriod(hi, -1, 0, 2, 0, -1, 1'b0);
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, 0, "R6 zero duty");
    runPeriod(hi, 2, 15, -1, 0, -1, 1'b0);
    check(hi, 0, "R6 zero held this period");
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, P, "R7 full duty");
  endtask

  task automatic testUnlink();
    runPeriod(hi, -1, 0, 2, 6, -1, 1'b0);
    runPeriod(hi, -1, 0, -1, 0, 1, 1'b0);
    check(hi, 6, "R8 staged value held after unlink");
    check(int'(pinBFree), 0, "R1 flag cleared");
    runPeriod(hi, -1, 0, -1, 0, -1, 1'b0);
    check(hi, P, "R8 register A after wrap");
  endtask

  initial begin
    while (!done && cyc < 200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testUnbuffered();
    testLink();
    testPingPong();
    testExtremes();
    testUnlink();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule